// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit gathers single-cycle event pulses from the receive, transmit, statistics-counter and remote-DMA logic of a network controller. Each pulse sets a sticky bit in an 8-bit status word. The host reads that word and acknowledges events by writing ones to the bits it has handled. A second 8-bit word, the enable mask, selects which status bits may raise the single level-sensitive interrupt line.

The most significant status bit is not a latched event. It is a registered copy of the controller's stopped-state input. It therefore reads as one while the controller is halted, and it can also raise the interrupt line if the mask enables it. Writes cannot clear it.

Both words share a small register port. A one-bit address selects the status word (0) or the mask word (1). Read data is combinational from the stored state.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is asserted and on release, the status word reads 0x80 (stopped bit set, bits 6..0 clear), the mask reads 0x00 and `irq_o` is low.
- R2: A one on `evt_i[n]` for n in 0..6 sets status bit n at the next clock edge. The fixed encoding is: received 0x01, transmitted 0x02, receive error 0x04, transmit error 0x08, overwrite warning 0x10, counter overflow 0x20, DMA complete 0x40.
- R3: A write to address 0 clears every status bit 6..0 whose write-data bit is one. Bits written with zero keep their value.
- R4: Writing 0xFF to address 0 clears all pending event bits 6..0.
- R5: When an event pulse and a clearing write hit the same bit in the same cycle, the bit is set after the edge.
- R6: A write to address 1 loads the mask. Reading address 1 returns it.
- R7: `irq_o` is high exactly when some status bit and its mask bit are both one. With a mask of zero it stays low whatever the status holds.
- R8: Status bit 7 equals `halted_i` as sampled at the previous clock edge. Writes to address 0 never change it.
- R9: Event bits are sticky. They accumulate across pulses and hold until cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 7 | Event pulses, bit n sets status bit n |
| halted_i | input | 1 | Controller stopped-state level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = status word, 1 = mask word |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed word |
| irq_o | output | 1 | Level interrupt request |

## Verification
If an event bit is lost or fails to clear, the status read shows it one cycle after the pulse or write. The interrupt line shows it in the same cycle whenever that bit is enabled. The bench therefore reads the status and mask words and samples the interrupt line in the cycle right after each stimulus.

Two cases are built so that a wrong priority or wrong ownership is visible at the ports:
- a set and a clear that collide on the same bit, where a design in which the clear wins would read the bit back as zero;
- a clearing write to the stopped bit, where a design that treats that bit as a latched event would drop it and deassert the interrupt line.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned HALT_POS = 7;
    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_MASK   = 1'b1;
endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
    parameter int unsigned EVT_N = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_i,
    input  logic             clr_en_i,
    input  logic [EVT_N-1:0] clr_sel_i,
    output logic [EVT_N-1:0] pend_o
);
    typedef struct packed {
        logic [EVT_N-1:0] pend;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [EVT_N-1:0] keep;

    for (genvar g = 0; g < EVT_N; g++) begin : g_keep
        // a set pulse outranks a clearing write on the same bit
        assign keep[g] = bank_q.pend[g] & ~(clr_en_i & clr_sel_i[g]);
    end

    always_comb begin
        bank_d      = bank_q;
        bank_d.pend = evt_i | keep;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign pend_o = bank_q.pend;
endmodule

// File: rtl/irq_halt_track.sv
module irq_halt_track (
    input  logic clk,
    input  logic rst_n,
    input  logic halted_i,
    output logic halt_o
);
    typedef struct packed {
        logic halt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.halt = halted_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '{halt: 1'b1};
        else        trk_q <= trk_d;
    end

    assign halt_o = trk_q.halt;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } msk_t;

    msk_t msk_d, msk_q;

    always_comb begin
        msk_d = msk_q;
        if (wr_en_i) msk_d.mask = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) msk_q <= '0;
        else        msk_q <= msk_d;
    end

    assign mask_o = msk_q.mask;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int unsigned STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-2:0] evt_i,
    input  logic              halted_i,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [STAT_W-1:0] reg_wdata_i,
    output logic [STAT_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    import irq_pkg::*;

    localparam int unsigned EVT_N = STAT_W - 1;

    logic              wr_stat, wr_mask;
    logic [EVT_N-1:0]  pend;
    logic              halt_bit;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] mask_q;

    assign wr_stat = reg_wr_i && (reg_addr_i == ADDR_STATUS);
    assign wr_mask = reg_wr_i && (reg_addr_i == ADDR_MASK);

    irq_evt_bank #(.EVT_N(EVT_N)) i_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .clr_en_i  (wr_stat),
        .clr_sel_i (reg_wdata_i[EVT_N-1:0]),
        .pend_o    (pend)
    );

    irq_halt_track i_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .halted_i (halted_i),
        .halt_o   (halt_bit)
    );

    irq_mask_reg #(.W(STAT_W)) i_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_mask),
        .wdata_i (reg_wdata_i),
        .mask_o  (mask_q)
    );

    assign stat_q      = {halt_bit, pend};
    assign reg_rdata_o = (reg_addr_i == ADDR_MASK) ? mask_q : stat_q;
    assign irq_o       = |(stat_q & mask_q);
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
    parameter int unsigned STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-2:0] evt_i,
    input logic              halted_i,
    input logic              reg_wr_i,
    input logic              reg_addr_i,
    input logic [STAT_W-1:0] reg_wdata_i,
    input logic              irq_o,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] mask_q
);
    localparam int unsigned EVT_N = STAT_W - 1;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_q[EVT_N-1:0] & $past(evt_i)) == $past(evt_i))); // R5

    AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !reg_addr_i) |=>
        ((stat_q[EVT_N-1:0] & $past(reg_wdata_i[EVT_N-1:0]) & ~$past(evt_i)) == '0)); // R3

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && !reg_addr_i) |=>
        ((stat_q[EVT_N-1:0] & $past(stat_q[EVT_N-1:0])) == $past(stat_q[EVT_N-1:0]))); // R9

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i) |=> (mask_q == $past(reg_wdata_i))); // R6

    AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o); // R7

    AST_HALT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_q[STAT_W-1] == $past(halted_i))); // R8
endmodule

bind irq_status_unit irq_status_unit_chk #(.STAT_W(STAT_W)) i_chk (.*);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
    localparam int PERIOD = 10;
    localparam int SEL_STAT = 0;
    localparam int SEL_MASK = 1;
    localparam int SEL_IRQ  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] evt_i = '0;
    logic       halted_i = 1'b1;
    logic       reg_wr_i = 1'b0;
    logic       reg_addr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        int         sel;
        logic [7:0] exp;
        string      req;
    } exp_t;

    exp_t sb[$];

    irq_status_unit i_irq_status_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .halted_i    (halted_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // driver: one cycle of stimulus, applied at the falling edge
    task automatic drive(input logic [6:0] e, input logic w, input logic a,
                         input logic [7:0] d);
        @(negedge clk);
        evt_i       = e;
        reg_wr_i    = w;
        reg_addr_i  = a;
        reg_wdata_i = d;
    endtask

    task automatic expect_now(input int sel, input logic [7:0] v, input string r);
        exp_t it;
        it.due = cyc;
        it.sel = sel;
        it.exp = v;
        it.req = r;
        sb.push_back(it);
    endtask

    // read status in a quiet cycle, then check status and irq
    task automatic look(input logic [7:0] st, input logic irq, input string r);
        drive(7'h00, 1'b0, 1'b0, 8'h00);
        expect_now(SEL_STAT, st, r);
        expect_now(SEL_IRQ, {7'h0, irq}, r);
    endtask

    // monitor: compares queued expectations a quarter period after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(PERIOD/4);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t it;
                logic [7:0] act;
                it = sb.pop_front();
                case (it.sel)
                    SEL_IRQ: act = {7'h0, irq_o};
                    default: act = reg_rdata_o;
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s sel=%0d actual=%02h expected=%02h",
                             it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        reg_addr_i = 1'b0;
        expect_now(SEL_STAT, 8'h80, "R1");
        expect_now(SEL_IRQ, 8'h00, "R1");
        @(negedge clk);
        reg_addr_i = 1'b1;
        expect_now(SEL_MASK, 8'h00, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        reg_addr_i = 1'b0;
        look(8'h80, 1'b0, "R1");
        // R8: stopped bit follows the halted level
        @(negedge clk);
        halted_i = 1'b0;
        look(8'h00, 1'b0, "R8");
        // R2: event encoding; R7: mask zero keeps irq low
        drive(7'h01, 1'b0, 1'b0, 8'h00);
        look(8'h01, 1'b0, "R2");
        drive(7'h40, 1'b0, 1'b0, 8'h00);
        look(8'h41, 1'b0, "R9");
        drive(7'h24, 1'b0, 1'b0, 8'h00);
        look(8'h65, 1'b0, "R2");
        // R3: ones clear, zeros keep; write to bit 7 ignored (R8)
        drive(7'h00, 1'b1, 1'b0, 8'h84);
        look(8'h61, 1'b0, "R3");
        drive(7'h00, 1'b1, 1'b0, 8'h00);
        look(8'h61, 1'b0, "R3");
        // R6: mask load and read back
        drive(7'h00, 1'b1, 1'b1, 8'h02);
        drive(7'h00, 1'b0, 1'b1, 8'h00);
        expect_now(SEL_MASK, 8'h02, "R6");
        expect_now(SEL_IRQ, 8'h00, "R7");
        drive(7'h02, 1'b0, 1'b0, 8'h00);
        look(8'h63, 1'b1, "R7");
        // R5: set and clear in the same cycle
        drive(7'h02, 1'b1, 1'b0, 8'h02);
        look(8'h63, 1'b1, "R5");
        // R4: write all ones
        drive(7'h00, 1'b1, 1'b0, 8'hFF);
        look(8'h00, 1'b0, "R4");
        // R8: stopped bit raises irq through the mask and ignores clears
        drive(7'h00, 1'b1, 1'b1, 8'h80);
        halted_i = 1'b1;
        look(8'h80, 1'b1, "R8");
        drive(7'h00, 1'b1, 1'b0, 8'h80);
        look(8'h80, 1'b1, "R8");
        drive(7'h00, 1'b1, 1'b1, 8'h00);
        look(8'h80, 1'b0, "R7");
        drive(7'h7F, 1'b0, 1'b0, 8'h00);
        look(8'hFF, 1'b0, "R7");
        drive(7'h00, 1'b1, 1'b1, 8'hFF);
        drive(7'h00, 1'b0, 1'b1, 8'h00);
        expect_now(SEL_MASK, 8'hFF, "R6");
        expect_now(SEL_IRQ, 8'h01, "R7");
        drive(7'h00, 1'b1, 1'b0, 8'hFF);
        look(8'h80, 1'b1, "R4");
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #(PERIOD * 200000);
        join_any
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule